// File: doc/BRIEF.md
# RGMII Transmit Formatter with Link Holdoff

This block sits between a MAC's byte-wide transmit path and the double-data-rate output stage of an RGMII interface. Each transmit clock it takes one byte, a transmit enable, a link indication and a speed code. It produces the two nibbles and the two control values that the DDR stage launches on the rising and falling halves of the next clock. Both halves are presented as ordinary single-rate signals, registered once. The MAC has no transmit-error input. Error is held at zero, so a bad frame can only be flagged by a corrupted CRC produced upstream.

The block also keeps the line quiet after the link comes up. Frames are suppressed for a fixed number of transmit clocks (4096 by default) counted with the link held high. After that window only a frame whose enable rises afterwards is let through. A frame whose enable was already high when the window closed is dropped in full. A frame that has been admitted runs to the end of its enable, whatever happens to the link meanwhile.

Top module: `rgmii_tx_fmt`

## Requirements
- R1: With speed code 2'b10 (gigabit), a passed cycle drives data bits 3:0 on the rising-half nibble and bits 7:4 on the falling-half nibble, one clock after the inputs are sampled.
- R2: With any other speed code (2'b00, 2'b01, 2'b11), a passed cycle drives data bits 3:0 on both halves and ignores bits 7:4.
- R3: Both control outputs equal the passed transmit enable, since transmit error is always zero.
- R4: Once the link input is sampled high, no frame passes until the link has been sampled high on HOLDOFF_CYCLES (4096) consecutive clocks.
- R5: The link input sampled low clears the holdoff count, so the next time the link comes up the full 4096-clock wait starts over.
- R6: After the holdoff expires, a frame is admitted only on a clock where the enable is high and was low on the previous clock. A frame already in progress at expiry is suppressed until its enable drops.
- R7: An admitted frame passes on every clock until its enable is sampled low, even if the link drops mid-frame.
- R8: On any clock that is not passed (blocked, idle or suppressed), both nibbles are zero and both control outputs are low.
- R9: Synchronous active-low reset drives all outputs to zero and clears the holdoff count and the frame state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_data | input | 8 | Transmit byte from the MAC |
| tx_en | input | 1 | Transmit enable, high for the length of a frame |
| link_up | input | 1 | Link status, high while the link is up |
| speed_sel | input | 2 | Speed code: 00 10M, 01 100M, 10 1000M, 11 reserved |
| txd_rise | output | 4 | Nibble for the rising half of the clock |
| txd_fall | output | 4 | Nibble for the falling half of the clock |
| txctl_rise | output | 1 | Control value for the rising half |
| txctl_fall | output | 1 | Control value for the falling half |

## Verification
Gigabit frames carry bytes whose two nibbles differ, so a swapped or repeated nibble is caught. The 10/100 and reserved-speed frames set the upper bits to non-zero values, which exposes any leak of bits 7:4. A frame is sent inside the holdoff window and another straddles its expiry, separating the count length, the rising-edge admission rule and suppression of the frame in progress. A link drop in the middle of a frame, followed by a second link-up, shows that admitted frames run to completion and that the wait restarts in full.

// File: rtl/rgmii_tx_pkg.sv
// Package: shared types and constants for the RGMII transmit formatter.
// Assumes an 8-bit MAC transmit bus split into two 4-bit nibbles.
package rgmii_tx_pkg;
    localparam int GMII_W = 8;
    localparam int NIB_W  = GMII_W / 2;

    typedef enum logic [1:0] {
        SPD_10   = 2'b00,
        SPD_100  = 2'b01,
        SPD_1000 = 2'b10,
        SPD_RSVD = 2'b11
    } speed_e;

    typedef struct packed {
        logic [NIB_W-1:0] rise;
        logic [NIB_W-1:0] fall;
    } nib_pair_t;
endpackage

// File: rtl/rgmii_tx_holdoff.sv
// Module: counts transmit clocks with the link held high and raises
// 'expired' once HOLDOFF_CYCLES such clocks have elapsed.
// Assumes link_up is already synchronous to clk. A low link clears the count.
module rgmii_tx_holdoff #(
    parameter int HOLDOFF_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_up,
    output logic expired
);
    localparam int CNT_W = (HOLDOFF_CYCLES > 1) ? $clog2(HOLDOFF_CYCLES) : 1;

    generate
        if (HOLDOFF_CYCLES == 0) begin : g_no_wait
            // Purpose: with no wait, follow the link one clock late.
            always_ff @(posedge clk) begin
                if (!rst_n) expired <= 1'b0;
                else        expired <= link_up;
            end
        end else begin : g_wait
            logic [CNT_W-1:0] cnt;

            // Purpose: advance the holdoff count while the link stays up.
            always_ff @(posedge clk) begin
                if (!rst_n || !link_up) begin
                    cnt     <= '0;
                    expired <= 1'b0;
                end else if (!expired) begin
                    if (cnt == CNT_W'(HOLDOFF_CYCLES - 1)) expired <= 1'b1;
                    else                                   cnt     <= cnt + 1'b1;
                end
            end

            AST_LINK_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                !link_up |=> !expired); // R5
            AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
                cnt <= CNT_W'(HOLDOFF_CYCLES - 1)); // R4
            AST_EXPIRE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(expired) |-> $past(cnt) == CNT_W'(HOLDOFF_CYCLES - 1)); // R4
        end
    endgenerate
endmodule

// File: rtl/rgmii_tx_gate.sv
// Module: decides on each clock whether the current transmit cycle passes.
// A frame is admitted on an enable rising edge after the holdoff has expired.
// An admitted frame is held open until its enable drops.
module rgmii_tx_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic expired,
    output logic pass
);
    logic en_q;
    logic in_frame;
    logic admit;

    // Purpose: detect a clean frame start once the holdoff window is over.
    always_comb admit = expired && tx_en && !en_q;

    // Purpose: a cycle passes if its frame is open or is opening now.
    always_comb pass = tx_en && (in_frame || admit);

    // Purpose: track the previous enable and whether an admitted frame is open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            in_frame <= 1'b0;
        end else begin
            en_q <= tx_en;
            if (!tx_en)     in_frame <= 1'b0;
            else if (admit) in_frame <= 1'b1;
        end
    end

    AST_OPEN_NEEDS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_frame) |-> $past(expired) && !$past(en_q)); // R6
    AST_FRAME_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !in_frame); // R7
endmodule

// File: rtl/rgmii_tx_nibble.sv
// Module: maps a transmit byte onto the rising and falling half nibbles.
// Gigabit splits the byte. Every other speed code repeats the low nibble.
module rgmii_tx_nibble
    import rgmii_tx_pkg::*;
(
    input  logic [GMII_W-1:0] data,
    input  logic [1:0]        speed,
    output nib_pair_t         pair
);
    // Purpose: choose the nibble order from the speed code.
    always_comb begin
        pair.rise = data[NIB_W-1:0];
        if (speed == SPD_1000) pair.fall = data[GMII_W-1:NIB_W];
        else                   pair.fall = data[NIB_W-1:0];
    end
endmodule

// File: rtl/rgmii_tx_fmt.sv
// Module: top of the RGMII transmit formatter. It holds off frames after
// link-up, admits clean frame starts and registers the DDR half-cycle values.
// Assumes all inputs are synchronous to clk and transmit error is always zero.
module rgmii_tx_fmt
    import rgmii_tx_pkg::*;
#(
    parameter int HOLDOFF_CYCLES = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GMII_W-1:0] tx_data,
    input  logic              tx_en,
    input  logic              link_up,
    input  logic [1:0]        speed_sel,
    output logic [NIB_W-1:0]  txd_rise,
    output logic [NIB_W-1:0]  txd_fall,
    output logic              txctl_rise,
    output logic              txctl_fall
);
    localparam logic TX_ERR = 1'b0;

    logic      expired;
    logic      pass;
    nib_pair_t pair;

    rgmii_tx_holdoff #(.HOLDOFF_CYCLES(HOLDOFF_CYCLES)) holdoff_i (
        .clk(clk), .rst_n(rst_n), .link_up(link_up), .expired(expired)
    );

    rgmii_tx_gate gate_i (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .expired(expired), .pass(pass)
    );

    rgmii_tx_nibble nibble_i (
        .data(tx_data), .speed(speed_sel), .pair(pair)
    );

    // Purpose: register the half-cycle values, zeroing every cycle that is not passed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txd_rise   <= '0;
            txd_fall   <= '0;
            txctl_rise <= 1'b0;
            txctl_fall <= 1'b0;
        end else begin
            txctl_rise <= pass;
            txctl_fall <= pass ^ TX_ERR;
            txd_rise   <= pass ? pair.rise : '0;
            txd_fall   <= pass ? pair.fall : '0;
        end
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !txctl_rise |-> (txd_rise == '0) && (txd_fall == '0)); // R8
    AST_CTL_HALVES: assert property (@(posedge clk) disable iff (!rst_n)
        txctl_rise == txctl_fall); // R3
    AST_LOW_SPEED_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        txctl_rise && ($past(speed_sel) != SPD_1000) |-> txd_rise == txd_fall); // R2
    AST_GIG_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        txctl_rise && ($past(speed_sel) == SPD_1000) |-> {txd_fall, txd_rise} == $past(tx_data)); // R1
    AST_CTL_FOLLOWS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        txctl_rise |-> $past(tx_en)); // R3
endmodule

// File: tb/rgmii_tx_fmt_tb_top.sv
module rgmii_tx_fmt_tb_top;
    localparam int HOLD = 4096;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_en = 1'b0;
    logic       link_up = 1'b0;
    logic [1:0] speed_sel = 2'b10;
    logic [3:0] txd_rise, txd_fall;
    logic       txctl_rise, txctl_fall;

    int checks = 0;
    int fails  = 0;

    // reference state built from the requirements
    int m_cnt = 0;
    bit m_done = 0;
    bit m_enq = 0;
    bit m_in = 0;

    logic [9:0] q_exp[$];
    string      q_tag[$];

    always #4 clk = ~clk;

    rgmii_tx_fmt dut_i (
        .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_en(tx_en),
        .link_up(link_up), .speed_sel(speed_sel), .txd_rise(txd_rise),
        .txd_fall(txd_fall), .txctl_rise(txctl_rise), .txctl_fall(txctl_fall)
    );

    task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b (rise,fall,ctl_r,ctl_f)", tag, act, exp);
        end
    endtask

    // driver: apply one cycle of stimulus and queue the expected output
    task automatic step(input bit en, input logic [7:0] d, input bit lnk,
                        input logic [1:0] spd, input string tag);
        bit pass, admit;
        logic [3:0] er, ef;
        @(negedge clk);
        tx_en = en; tx_data = d; link_up = lnk; speed_sel = spd;
        admit = m_done && en && !m_enq;
        pass  = en && (m_in || admit);
        er = '0; ef = '0;
        if (pass) begin
            er = d[3:0];
            ef = (spd == 2'b10) ? d[7:4] : d[3:0];
        end
        q_exp.push_back({er, ef, pass, pass});
        q_tag.push_back(tag);
        if (!en) m_in = 0; else if (admit) m_in = 1;
        m_enq = en;
        if (!lnk) begin m_cnt = 0; m_done = 0; end
        else if (!m_done) begin
            if (m_cnt == HOLD - 1) m_done = 1; else m_cnt++;
        end
    endtask

    task automatic idle(input int n, input bit lnk, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 8'hA5, lnk, 2'b10, tag);
    endtask

    task automatic frame(input int n, input logic [1:0] spd, input bit lnk, input string tag);
        for (int i = 0; i < n; i++) step(1'b1, 8'(i * 37 + 8'h5C), lnk, spd, tag);
    endtask

    // monitor: pop and compare after each clock edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_exp.size() > 0) begin
                logic [9:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                check(t, {txd_rise, txd_fall, txctl_rise, txctl_fall}, e);
            end
        end
    end

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R9: reset with busy inputs keeps outputs at zero
        tx_en = 1; link_up = 1; tx_data = 8'hFF;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R9", {txd_rise, txd_fall, txctl_rise, txctl_fall}, 10'b0);
        tx_en = 0; link_up = 0; rst_n = 1;

        // R4: frames inside the holdoff window are blocked
        idle(100, 1'b1, "R4");
        frame(10, 2'b10, 1'b1, "R4");
        idle(3970, 1'b1, "R4");
        // R6: a frame straddling expiry is suppressed in full
        frame(30, 2'b10, 1'b1, "R6");
        idle(3, 1'b1, "R8");
        frame(16, 2'b10, 1'b1, "R1");
        idle(2, 1'b1, "R8");
        frame(12, 2'b01, 1'b1, "R2");
        idle(1, 1'b1, "R8");
        frame(8, 2'b00, 1'b1, "R2");
        idle(1, 1'b1, "R8");
        frame(8, 2'b11, 1'b1, "R2");
        idle(1, 1'b1, "R6");
        frame(6, 2'b10, 1'b1, "R3");

        // R7: link drop mid-frame does not cut the admitted frame
        idle(2, 1'b1, "R8");
        frame(5, 2'b10, 1'b1, "R7");
        frame(15, 2'b10, 1'b0, "R7");
        idle(5, 1'b0, "R8");

        // R5: wait restarts in full on the next link rise
        idle(50, 1'b1, "R5");
        frame(10, 2'b10, 1'b1, "R5");
        idle(4030, 1'b1, "R5");
        frame(10, 2'b01, 1'b1, "R5");
        idle(20, 1'b1, "R5");
        frame(10, 2'b10, 1'b1, "R5");
        idle(3, 1'b1, "R8");

        repeat (4) @(posedge clk);
        #3;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule